// File: doc/BRIEF.md
# LED Dimming PWM Generator with Duty Scaling

This block drives the dimming waveform of an LED backlight. The brightness can come from three places: the duty cycle of an external PWM pin, an 8-bit brightness level held in a register elsewhere on the chip, or the product of the two. Two select inputs choose the source. The external pin goes through a two-flop synchronizer. Its duty is then measured between consecutive rising edges and normalized to an 8-bit level. That measurement is combined with the brightness level when the selected mode calls for it.

The waveform that leaves the block is always rebuilt from scratch on a private period of 255 steps, each `OUT_DIV` clocks long. The output rate therefore never depends on the frequency of the external pin. A new level takes effect only where an output period begins, so a pulse is never cut short. A pin that stops toggling is detected by a timeout. Its steady level is then read as 0% or 100%.

Top module: `pwm_dim_ctrl`

## Requirements
- R1: With `src_pin_i` = 1, the output duty equals the measured pin duty, whatever `brt_i` and `reg_only_i` hold.
- R2: With `src_pin_i` = 0 and `reg_only_i` = 1, the output is high for exactly `brt_i` of the 255 steps in each output period.
- R3: With `src_pin_i` = 0 and `reg_only_i` = 0, the output level is (`brt_i` x M + 127) / 255 in integer arithmetic, where M is the measured pin level (0..255). This is the product rounded to the nearest 8-bit level.
- R4: `brt_i` = 0 holds the output low in both modes that use the register.
- R5: For a pin waveform of period P clocks that is high for H clocks (0 < H < P), the measured level is (H x 255 + P/2) / P in integer arithmetic. It is refreshed once per complete period, at each rising edge that follows an earlier rising edge.
- R6: When no rising edge is seen for `TIMEOUT` clocks, the measured level becomes 255 if the synchronized pin is high and 0 if it is low.
- R7: An output period lasts 255 x `OUT_DIV` clocks, whatever the pin frequency. A level of 1..254 gives exactly one pulse per period. A pulse begins only at the first step of a period, and the level in use changes only there.
- R8: After reset the output is low for the whole first output period, and the measured level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_pin_i | input | 1 | External PWM pin, asynchronous to clk |
| brt_i | input | 8 | Brightness level from the register file, 0..255 |
| src_pin_i | input | 1 | 1: the pin alone sets the brightness |
| reg_only_i | input | 1 | With src_pin_i = 0: 1 uses the register alone, 0 uses the scaled product |
| pwm_o | output | 1 | Dimming PWM output |

## Verification
Several properties are checked on every clock cycle. A pulse may rise only at the first step of an output period, and the level in use may change only there. The scaled level never exceeds either of its two factors, and a zero brightness always forces the output dark in the register modes. The measured level holds between edges, and it settles to the static extreme once the timeout runs out. The exact rounded levels, the high-count of each output period, the independence from the pin period and the response to a stalled pin can only be shown by the bench. It sweeps every mode against a set of brightness values and pin waveforms, then counts high steps and pulses over a full output period.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;
   localparam int LVL_W   = 8;
   localparam int LVL_TOP = 255;

   typedef enum logic [1:0] {
      SRC_PIN    = 2'd0,
      SRC_REG    = 2'd1,
      SRC_SCALED = 2'd2
   } dim_src_e;

   // (a*b)/255 rounded to the nearest level
   function automatic logic [LVL_W-1:0] scale_lvl(input logic [LVL_W-1:0] a,
                                                  input logic [LVL_W-1:0] b);
      logic [2*LVL_W-1:0] prod;
      prod = (2*LVL_W)'(a) * (2*LVL_W)'(b) + (2*LVL_W)'(127);
      return LVL_W'(prod / (2*LVL_W)'(LVL_TOP));
   endfunction
endpackage

// File: rtl/pwm_in_meter.sv
module pwm_in_meter #(
   parameter int CNT_W   = 16,
   parameter int TIMEOUT = 40000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   output logic [7:0] lvl_o
);
   localparam int NW = CNT_W + 8;
   localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT);

   initial begin
      assert (TIMEOUT >= 4 && TIMEOUT < (2**CNT_W))
         else $error("pwm_in_meter: TIMEOUT must fit in CNT_W bits");
   end

   logic [1:0]       sync_q;
   logic             lvl_d_q;
   logic [CNT_W-1:0] per_q, hi_q;
   logic             armed_q;
   logic [7:0]       lvl_q;
   logic             s_pin, rise, stalled;
   logic [NW-1:0]    num, quo;

   assign s_pin   = sync_q[1];
   assign rise    = s_pin & ~lvl_d_q;
   assign stalled = (per_q == TMO);

   always_comb begin
      num = NW'(hi_q) * NW'(255) + NW'(per_q >> 1);
      quo = (per_q == '0) ? '0 : num / NW'(per_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         lvl_d_q <= 1'b0;
         per_q   <= '0;
         hi_q    <= '0;
         armed_q <= 1'b0;
         lvl_q   <= '0;
      end else begin
         sync_q  <= {sync_q[0], pin_i};
         lvl_d_q <= s_pin;
         if (rise) begin
            if (armed_q) lvl_q <= quo[7:0];
            armed_q <= 1'b1;
            per_q   <= CNT_W'(1);
            hi_q    <= CNT_W'(1);
         end else if (stalled) begin
            armed_q <= 1'b0;
            lvl_q   <= s_pin ? 8'hFF : 8'h00;
         end else begin
            per_q <= per_q + 1'b1;
            hi_q  <= hi_q + CNT_W'(s_pin);
         end
      end
   end

   assign lvl_o = lvl_q;

   // R5: level only moves on a rising edge or after a stall
   a_r5_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && !stalled) |=> $stable(lvl_o));
   // R6: stalled high pin reads as full scale
   a_r6_stall_high: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && !rise && s_pin) |=> (lvl_o == 8'hFF));
   // R6: stalled low pin reads as zero
   a_r6_stall_low: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && !s_pin) |=> (lvl_o == 8'h00));
endmodule

// File: rtl/pwm_src_mux.sv
module pwm_src_mux
   import pwm_dim_pkg::*;
(
   input  logic             src_pin_i,
   input  logic             reg_only_i,
   input  logic [LVL_W-1:0] brt_i,
   input  logic [LVL_W-1:0] meas_i,
   output logic [LVL_W-1:0] lvl_o
);
   dim_src_e src;

   always_comb begin
      if (src_pin_i)       src = SRC_PIN;
      else if (reg_only_i) src = SRC_REG;
      else                 src = SRC_SCALED;
   end

   always_comb begin
      case (src)
         SRC_PIN:    lvl_o = meas_i;
         SRC_REG:    lvl_o = brt_i;
         default:    lvl_o = scale_lvl(brt_i, meas_i);
      endcase
   end
endmodule

// File: rtl/pwm_out_gen.sv
module pwm_out_gen #(
   parameter int OUT_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] lvl_i,
   output logic       pwm_o
);
   localparam logic [7:0] LAST_STEP = 8'd254;

   initial begin
      assert (OUT_DIV >= 1) else $error("pwm_out_gen: OUT_DIV must be at least 1");
   end

   logic       tick;
   logic [7:0] step_q;
   logic [7:0] lvl_q;

   generate
      if (OUT_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(OUT_DIV);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           pre_q <= '0;
            else if (pre_q == PW'(OUT_DIV - 1))   pre_q <= '0;
            else                                  pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PW'(OUT_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         lvl_q  <= '0;
      end else if (tick) begin
         if (step_q == LAST_STEP) begin
            step_q <= '0;
            lvl_q  <= lvl_i;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   assign pwm_o = (step_q < lvl_q);

   // R7: pulses start only at the first step of a period
   a_r7_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> (step_q == 8'd0));
   // R7: level in use is frozen away from the period start
   a_r7_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != 8'd0) |-> $stable(lvl_q));
endmodule

// File: rtl/pwm_dim_ctrl.sv
module pwm_dim_ctrl #(
   parameter int CNT_W   = 16,
   parameter int TIMEOUT = 40000,
   parameter int OUT_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_pin_i,
   input  logic [7:0] brt_i,
   input  logic       src_pin_i,
   input  logic       reg_only_i,
   output logic       pwm_o
);
   logic [7:0] meas_lvl;
   logic [7:0] mix_lvl;

   pwm_in_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pwm_pin_i),
      .lvl_o (meas_lvl)
   );

   pwm_src_mux u_mux (
      .src_pin_i  (src_pin_i),
      .reg_only_i (reg_only_i),
      .brt_i      (brt_i),
      .meas_i     (meas_lvl),
      .lvl_o      (mix_lvl)
   );

   pwm_out_gen #(.OUT_DIV(OUT_DIV)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (mix_lvl),
      .pwm_o (pwm_o)
   );

   // R4: zero brightness darkens both register modes
   a_r4_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_pin_i && brt_i == 8'd0) |-> (mix_lvl == 8'd0));
   // R3: scaled level never exceeds either factor
   a_r3_scaled_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_pin_i && !reg_only_i) |-> (mix_lvl <= brt_i && mix_lvl <= meas_lvl));
endmodule

// File: tb/tb_pwm_dim_ctrl.sv
module tb_pwm_dim_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_pin = 1'b0;
   logic [7:0] brt = 8'd255;
   logic       src_pin = 1'b0;
   logic       reg_only = 1'b1;
   logic       pwm_out;

   int nvec = 0, nfail = 0;
   int in_per = 100, in_hi = 30, phase = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pwm_dim_ctrl #(.CNT_W(10), .TIMEOUT(600), .OUT_DIV(1)) dut (
      .clk(clk), .rst_n(rst_n), .pwm_pin_i(pwm_pin), .brt_i(brt),
      .src_pin_i(src_pin), .reg_only_i(reg_only), .pwm_o(pwm_out));

   always @(negedge clk) begin
      pwm_pin <= (phase < in_hi);
      phase   <= (phase + 1 >= in_per) ? 0 : phase + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(output int hi, output int rises);
      bit prev;
      hi = 0; rises = 0; prev = pwm_out;
      repeat (255) begin
         @(negedge clk);
         if (pwm_out) hi++;
         if (pwm_out && !prev) rises++;
         prev = pwm_out;
      end
   endtask

   function automatic int exp_meas(input int p, input int h);
      if (h == 0) return 0;
      if (h >= p) return 255;
      return (h * 255 + p / 2) / p;
   endfunction

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      int pers[5] = '{100, 64, 200, 50, 50};
      int his[5]  = '{30, 63, 1, 0, 50};
      int brts[4] = '{0, 77, 128, 255};
      int hi, rises, lows;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R8: output dark through the first output period
      lows = 0;
      repeat (250) begin
         @(negedge clk);
         if (pwm_out) lows++;
      end
      check("R8", lows, 0);
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 5; p++) begin
            for (int b = 0; b < 4; b++) begin
               int meas, expv;
               string tag;
               @(negedge clk);
               src_pin  = m[1];
               reg_only = m[0];
               brt      = 8'(brts[b]);
               in_per   = pers[p];
               in_hi    = his[p];
               meas = exp_meas(pers[p], his[p]);
               if (m[1]) begin
                  expv = meas;
                  tag  = (his[p] == 0 || his[p] >= pers[p]) ? "R6" :
                         (p == 0) ? "R1" : "R5";
               end else if (m[0]) begin
                  expv = brts[b];
                  tag  = (brts[b] == 0) ? "R4" : "R2";
               end else begin
                  expv = (brts[b] * meas + 127) / 255;
                  tag  = (brts[b] == 0) ? "R4" :
                         (his[p] == 0 || his[p] >= pers[p]) ? "R6" : "R3";
               end
               repeat (1400) @(negedge clk);
               measure(hi, rises);
               check(tag, hi, expv);
               if (expv > 0 && expv < 255) check("R7", rises, 1);
            end
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule